// File: doc/BRIEF.md
# Command-Prefixed Serial Register Interface

This block is the slave side of a four-wire serial port that gives a host access to a small register file. Each access opens with an 8-bit command byte. The command picks a register and says whether the next transfer reads it or writes it. The block then moves that register across the wire, most significant bit first, using the register's own width. When the access is done, the block waits for a new command.

A continuous-read mode drops the command phase. While the mode is active, every transfer reads the data register. The host can follow each new conversion result without sending a prefix. The conversion results arrive on a parallel strobe-and-value input. A ready output tells the host that an unread result is waiting.

The serial clock idles high and is sampled by the system clock. The register file holds the mode, filter, offset-DAC and test words. It also holds three offset words and three gain words, and the channel field of the mode word selects which of these banks the host reaches.

Top module: `ser_regif`

## Requirements
- R1: Command byte fields: bit 7 write-enable, bits 5:4 transfer kind, bits 2:0 register select. Transfer kinds: 00 writes the register, 01 reads it, 10 enters continuous read, 11 does nothing. Register selects: 0 status, 1 data, 2 mode, 3 filter, 4 offset-DAC, 5 offset, 6 gain, 7 test. Kind 10 acts only with select 1, and kind 00 with select 0 starts no transfer. After a single access the next byte is taken as a command.
- R2: Register widths are: status 8, mode 16, filter 24, offset-DAC 8, offset 24, gain 24, test 24. Bits go most significant first. The output changes on a serial clock falling edge, and the input is sampled on the rising edge.
- R3: After reset the registers read: status 0xC0, data 0x000000, mode 0x01B0, filter 0x200010, offset-DAC 0x20, every offset bank 0x800000, every gain bank 0x59AEE7, test 0x000000. The ready output is low.
- R4: Mode bit 8 sets the data register width. When it is 1, all 24 result bits are read. When it is 0, 16 bits are read, and these are the upper 16 bits of the result.
- R5: Mode bits 1:0 select the offset and gain bank for addresses 5 and 6. Values 0, 1 and 2 reach banks 0, 1 and 2. Value 3 reaches bank 2.
- R6: Status bits:
  - bit 7 is 1 when no unread result is waiting;
  - bit 6 is 1 until the first result arrives after reset;
  - bit 5 is 1 when mode bits 15:13 equal 011;
  - bit 4 reads 0;
  - bits 3:0 mirror mode bits 15:12.
- R7: The ready output rises one cycle after a result strobe that does not collide with a data read. It falls when a data-register read completes.
- R8: A result that arrives while a data read is shifting does not change the word being read. That result is applied once the read ends, and ready rises again.
- R9: Writes aimed at the status or data address change no register.
- R10: Raising chip select aborts the access and clears the bit counter. A partly shifted write is discarded, and the next access starts with a command byte.
- R11: Command 0x21 enters continuous read. After that, each chip-select-low window of data-width clocks returns the data register with no command. If the first 8 bits sent by the host in such a window have bit 7 equal to 0 and bits 5:4 equal to 11, the mode ends after that window.
- R12: A command byte with bit 7 set is ignored, and the next byte is again taken as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| cs_ni | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data from the host |
| res_vld_i | input | 1 | One-cycle strobe for a new conversion result |
| res_data_i | input | 24 | Conversion result value |
| sdo_o | output | 1 | Serial data to the host |
| rdy_o | output | 1 | High while an unread result is waiting |

## Verification
The hardest case to reach is a result strobe that lands while a data read is half shifted. The bench reaches it by splitting one read into two shift calls and pulsing the strobe between them. It then checks that the word read out is the old result, that ready comes back after the read, and that a second read returns the new value. Continuous read is also hard to reach: it has no command phase, so the exit byte has to ride on the input line during a streaming read. After that read, an ordinary command must work again.

// File: rtl/ser_regif_pkg.sv
package ser_regif_pkg;
  localparam int unsigned REG_W = 24;
  localparam int unsigned CNT_W = $clog2(REG_W + 1);

  typedef enum logic [2:0] {
    A_STAT = 3'd0, A_DATA = 3'd1, A_MODE = 3'd2, A_FILT = 3'd3,
    A_DAC  = 3'd4, A_OFFS = 3'd5, A_GAIN = 3'd6, A_TEST = 3'd7
  } addr_e;

  typedef enum logic [1:0] {
    RW_WR = 2'b00, RW_RD = 2'b01, RW_CONT_ON = 2'b10, RW_NOP = 2'b11
  } rw_e;

  typedef enum logic {PH_CMD = 1'b0, PH_XFER = 1'b1} phase_e;

  localparam logic [15:0]      MODE_RST = 16'h01B0;
  localparam logic [REG_W-1:0] FILT_RST = 24'h200010;
  localparam logic [7:0]       DAC_RST  = 8'h20;
  localparam logic [REG_W-1:0] OFFS_RST = 24'h800000;
  localparam logic [REG_W-1:0] GAIN_RST = 24'h59AEE7;
  localparam logic [REG_W-1:0] TEST_RST = 24'h000000;

  localparam int unsigned MODE_WL_BIT = 8;

  function automatic logic [CNT_W-1:0] reg_len(addr_e a, logic wl);
    case (a)
      A_STAT, A_DAC: reg_len = CNT_W'(8);
      A_MODE:        reg_len = CNT_W'(16);
      A_DATA:        reg_len = wl ? CNT_W'(24) : CNT_W'(16);
      default:       reg_len = CNT_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/ser_edge.sv
module ser_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b1;
    else         sclk_q <= sclk_i;
  end

  assign rise_o = sclk_i & ~sclk_q;
  assign fall_o = ~sclk_i & sclk_q;
endmodule

// File: rtl/ser_result.sv
module ser_result #(
  parameter int unsigned DW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [DW-1:0] val_i,
  input  logic          busy_i,
  input  logic          rd_done_i,
  output logic [DW-1:0] data_o,
  output logic          rdy_o,
  output logic          seen_o
);
  logic [DW-1:0] data_q, pend_q;
  logic          pend_vld_q, rdy_q, seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q     <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      rdy_q      <= 1'b0;
      seen_q     <= 1'b0;
    end else begin
      if (rd_done_i) rdy_q <= 1'b0;
      if (vld_i && busy_i) begin
        pend_q     <= val_i;
        pend_vld_q <= 1'b1;
      end else if (vld_i) begin
        data_q     <= val_i;
        pend_vld_q <= 1'b0;
        rdy_q      <= 1'b1;
        seen_q     <= 1'b1;
      end else if (pend_vld_q && !busy_i) begin
        data_q     <= pend_q;
        pend_vld_q <= 1'b0;
        rdy_q      <= 1'b1;
        seen_q     <= 1'b1;
      end
    end
  end

  assign data_o = data_q;
  assign rdy_o  = rdy_q;
  assign seen_o = seen_q;

  p_rdy_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_i |=> !rdy_o);
  p_rdy_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !busy_i) |=> (rdy_o && data_o == $past(val_i)));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(data_o));
  p_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && busy_i) |=> pend_vld_q);
endmodule

// File: rtl/ser_regfile.sv
module ser_regfile
  import ser_regif_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  addr_e            wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  addr_e            rd_addr_i,
  input  logic [REG_W-1:0] data_i,
  input  logic             rdy_i,
  input  logic             seen_i,
  output logic             wl_o,
  output logic [REG_W-1:0] rd_val_o
);
  logic [15:0]      mode_q;
  logic [REG_W-1:0] filt_q, test_q;
  logic [7:0]       dac_q;
  logic [REG_W-1:0] offs_q [NUM_BANKS];
  logic [REG_W-1:0] gain_q [NUM_BANKS];
  logic [1:0]       bank;

  // channel values past the last bank alias onto it
  assign bank = (int'(mode_q[1:0]) >= NUM_BANKS) ? 2'(NUM_BANKS - 1) : mode_q[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      filt_q <= FILT_RST;
      dac_q  <= DAC_RST;
      test_q <= TEST_RST;
      for (int b = 0; b < NUM_BANKS; b++) begin
        offs_q[b] <= OFFS_RST;
        gain_q[b] <= GAIN_RST;
      end
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_MODE: mode_q <= wr_data_i[15:0];
        A_FILT: filt_q <= wr_data_i;
        A_DAC:  dac_q  <= wr_data_i[7:0];
        A_TEST: test_q <= wr_data_i;
        A_OFFS: offs_q[bank] <= wr_data_i;
        A_GAIN: gain_q[bank] <= wr_data_i;
        default: ;
      endcase
    end
  end

  assign wl_o = mode_q[MODE_WL_BIT];

  always_comb begin
    case (rd_addr_i)
      A_STAT: rd_val_o = {16'b0, ~rdy_i, ~seen_i, (mode_q[15:13] == 3'b011),
                          1'b0, mode_q[15:12]};
      A_DATA: rd_val_o = wl_o ? data_i : {8'b0, data_i[REG_W-1:8]};
      A_MODE: rd_val_o = {8'b0, mode_q};
      A_FILT: rd_val_o = filt_q;
      A_DAC:  rd_val_o = {16'b0, dac_q};
      A_OFFS: rd_val_o = offs_q[bank];
      A_GAIN: rd_val_o = gain_q[bank];
      default: rd_val_o = test_q;
    endcase
  end

  p_mode_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == A_MODE) |=> $stable(mode_q));
  p_ro_filt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i == A_STAT || wr_addr_i == A_DATA)) |=> $stable(filt_q));
endmodule

// File: rtl/ser_regif.sv
module ser_regif
  import ser_regif_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sclk_i,
  input  logic        cs_ni,
  input  logic        sdi_i,
  input  logic        res_vld_i,
  input  logic [23:0] res_data_i,
  output logic        sdo_o,
  output logic        rdy_o
);
  phase_e           phase_q;
  addr_e            tgt_q;
  logic             wr_q, cont_q, active_q, sdo_q;
  logic [CNT_W-1:0] bit_cnt_q, len;
  logic [REG_W-1:0] rx_q, tx_q, rx_next, rd_val, rd_word, data;
  logic             rise, fall, wl, last, seen, wr_en, rd_done, data_busy;
  logic [7:0]       cmd_byte;
  rw_e              cmd_rw;
  addr_e            cmd_sel;

  ser_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .rise_o(rise), .fall_o(fall)
  );

  assign rx_next  = {rx_q[REG_W-2:0], sdi_i};
  assign cmd_byte = rx_next[7:0];
  assign cmd_rw   = rw_e'(cmd_byte[5:4]);
  assign cmd_sel  = addr_e'(cmd_byte[2:0]);
  assign len      = reg_len(tgt_q, wl);
  assign last     = (bit_cnt_q == len - CNT_W'(1));
  assign rd_word  = rd_val << (CNT_W'(REG_W) - len);

  assign wr_en     = rise && !cs_ni && phase_q == PH_XFER && wr_q && last;
  assign rd_done   = rise && !cs_ni && phase_q == PH_XFER && !wr_q && last && tgt_q == A_DATA;
  assign data_busy = active_q && !wr_q && tgt_q == A_DATA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_CMD;
      tgt_q     <= A_STAT;
      wr_q      <= 1'b0;
      cont_q    <= 1'b0;
      active_q  <= 1'b0;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      sdo_q     <= 1'b0;
    end else if (cs_ni) begin
      bit_cnt_q <= '0;
      active_q  <= 1'b0;
      if (!cont_q) phase_q <= PH_CMD;
    end else begin
      if (fall) begin
        // first falling edge of a transfer loads the live register value
        if (phase_q == PH_XFER && !active_q) begin
          sdo_q    <= rd_word[REG_W-1];
          tx_q     <= rd_word << 1;
          active_q <= 1'b1;
        end else begin
          sdo_q <= tx_q[REG_W-1];
          tx_q  <= tx_q << 1;
        end
      end
      if (rise) begin
        rx_q <= rx_next;
        if (phase_q == PH_CMD) begin
          if (bit_cnt_q == CNT_W'(7)) begin
            bit_cnt_q <= '0;
            if (!cmd_byte[7]) begin
              case (cmd_rw)
                RW_WR: if (cmd_sel != A_STAT) begin
                  phase_q <= PH_XFER; tgt_q <= cmd_sel; wr_q <= 1'b1;
                end
                RW_RD: begin
                  phase_q <= PH_XFER; tgt_q <= cmd_sel; wr_q <= 1'b0;
                end
                RW_CONT_ON: if (cmd_sel == A_DATA) begin
                  phase_q <= PH_XFER; tgt_q <= A_DATA; wr_q <= 1'b0; cont_q <= 1'b1;
                end
                default: ;
              endcase
            end
          end else begin
            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
          end
        end else begin
          if (cont_q && bit_cnt_q == CNT_W'(7) && !cmd_byte[7] && cmd_rw == RW_NOP)
            cont_q <= 1'b0;
          if (last) begin
            bit_cnt_q <= '0;
            active_q  <= 1'b0;
            if (!cont_q) phase_q <= PH_CMD;
          end else begin
            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
          end
        end
      end
    end
  end

  ser_result #(.DW(REG_W)) u_result (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(res_vld_i), .val_i(res_data_i),
    .busy_i(data_busy), .rd_done_i(rd_done), .data_o(data), .rdy_o(rdy_o),
    .seen_o(seen)
  );

  ser_regfile #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(tgt_q),
    .wr_data_i(rx_next), .rd_addr_i(tgt_q), .data_i(data), .rdy_i(rdy_o),
    .seen_i(seen), .wl_o(wl), .rd_val_o(rd_val)
  );

  assign sdo_o = sdo_q;

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q < CNT_W'(REG_W));
  p_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (bit_cnt_q == '0 && !active_q));
  p_cont_phase_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont_q |-> phase_q == PH_XFER);
  p_ignore_we_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !cs_ni && phase_q == PH_CMD && bit_cnt_q == CNT_W'(7) && cmd_byte[7])
    |=> phase_q == PH_CMD);
endmodule

// File: tb/tb_ser_regif.sv
module tb_ser_regif;
  localparam int HB = 4;

  logic        clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0;
  logic        res_vld = 1'b0;
  logic [23:0] res_data = '0;
  logic        sdo, rdy;
  int          tests = 0, fails = 0;
  bit          done = 1'b0;

  logic [15:0] mode_m = 16'h01B0;
  logic        rdy_m = 1'b0, seen_m = 1'b0;

  always #10 clk = ~clk;

  ser_regif dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi),
    .res_vld_i(res_vld), .res_data_i(res_data), .sdo_o(sdo), .rdy_o(rdy)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic shift(input int n, input logic [23:0] din, output logic [23:0] dout);
    dout = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0; sdi = din[i]; wt(HB);
      dout = {dout[22:0], sdo};
      sclk = 1'b1; wt(HB);
    end
  endtask

  task automatic cs_lo(); cs_n = 1'b0; wt(HB); endtask
  task automatic cs_hi(); cs_n = 1'b1; wt(HB); endtask

  task automatic rd(input logic [2:0] a, input int n, output logic [23:0] v);
    logic [23:0] junk;
    cs_lo(); shift(8, {16'b0, 5'b00010, a}, junk); shift(n, '0, v); cs_hi();
  endtask

  task automatic wr(input logic [2:0] a, input int n, input logic [23:0] v);
    logic [23:0] junk;
    cs_lo(); shift(8, {16'b0, 5'b00000, a}, junk); shift(n, v, junk); cs_hi();
  endtask

  task automatic set_mode(input logic [15:0] m);
    wr(3'd2, 16, {8'b0, m}); mode_m = m;
  endtask

  task automatic push(input logic [23:0] v);
    res_data = v; res_vld = 1'b1; wt(1); res_vld = 1'b0; wt(2);
    rdy_m = 1'b1; seen_m = 1'b1;
  endtask

  function automatic logic [23:0] exp_stat();
    return {16'b0, ~rdy_m, ~seen_m, (mode_m[15:13] == 3'b011), 1'b0, mode_m[15:12]};
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [23:0] v, v2, junk;
    logic [23:0] offs_e [3];
    logic [23:0] gain_e [3];
    wt(5); rst_n = 1'b1; wt(5);

    // R3 reset state
    chk("R3 rdy", {23'b0, rdy}, 24'h0);
    rd(3'd0, 8, v);  chk("R3/R6 status", v, 24'hC0);
    rd(3'd2, 16, v); chk("R3 mode", v, 24'h01B0);
    rd(3'd3, 24, v); chk("R3 filter", v, 24'h200010);
    rd(3'd4, 8, v);  chk("R3 dac", v, 24'h20);
    rd(3'd7, 24, v); chk("R3 test", v, 24'h0);
    rd(3'd1, 24, v); chk("R3 data", v, 24'h0);
    for (int c = 0; c < 3; c++) begin
      set_mode(16'h01B0 | 16'(c));
      rd(3'd5, 24, v); chk("R3 offs bank", v, 24'h800000);
      rd(3'd6, 24, v); chk("R3 gain bank", v, 24'h59AEE7);
    end

    // R5 bank sweep
    for (int c = 0; c < 3; c++) begin
      set_mode(16'h01B0 | 16'(c));
      offs_e[c] = 24'h0A0B0C + 24'(c + 1) * 24'h100000;
      gain_e[c] = 24'h3C0000 ^ (24'(c) * 24'h111111);
      wr(3'd5, 24, offs_e[c]); wr(3'd6, 24, gain_e[c]);
    end
    for (int c = 0; c < 4; c++) begin
      set_mode(16'h01B0 | 16'(c));
      rd(3'd5, 24, v); chk("R5 offs sel", v, offs_e[(c > 2) ? 2 : c]);
      rd(3'd6, 24, v); chk("R5 gain sel", v, gain_e[(c > 2) ? 2 : c]);
    end

    // R2 widths and bit order over patterns
    foreach (offs_e[k]) begin end
    for (int p = 0; p < 4; p++) begin
      logic [23:0] pat;
      pat = (p == 0) ? 24'hA5A5A5 : (p == 1) ? 24'h5A5A5A : (p == 2) ? 24'hFFFFFF : 24'h000001;
      wr(3'd3, 24, pat); wr(3'd7, 24, ~pat); wr(3'd4, 8, {16'b0, pat[7:0]});
      rd(3'd3, 24, v); chk("R2 filter", v, pat);
      rd(3'd7, 24, v); chk("R2 test", v, ~pat);
      rd(3'd4, 8, v);  chk("R2 dac", v, {16'b0, pat[7:0]});
    end

    // R12 write-enable byte ignored, following 0xFF bytes too
    cs_lo(); shift(8, 24'h82, junk); shift(16, 24'hFFFF, junk); cs_hi();
    rd(3'd2, 16, v); chk("R12 mode untouched", v, {8'b0, mode_m});

    // R1 no-op kinds then a read in the same window
    cs_lo(); shift(8, 24'h32, junk); shift(8, 24'h12, junk); shift(16, 0, v); cs_hi();
    chk("R1 nop then read", v, {8'b0, mode_m});
    cs_lo(); shift(8, 24'h22, junk); shift(8, 24'h12, junk); shift(16, 0, v); cs_hi();
    chk("R1 cont-on wrong sel", v, {8'b0, mode_m});
    cs_lo(); shift(8, 24'h00, junk); shift(8, 24'h13, junk); shift(24, 0, v); cs_hi();
    chk("R1 addr0 write is command only", v, 24'h000001);

    // R7 / R9
    push(24'h123456);
    chk("R7 rdy set", {23'b0, rdy}, 24'h1);
    rd(3'd0, 8, v); chk("R6 status pending", v, exp_stat());
    wr(3'd1, 24, 24'hFFFFFF);
    chk("R9 data write no rdy effect", {23'b0, rdy}, 24'h1);
    rd(3'd1, 24, v); rdy_m = 1'b0;
    chk("R9 data unchanged", v, 24'h123456);
    chk("R7 rdy cleared", {23'b0, rdy}, 24'h0);

    // R4 16-bit data word, next command follows after 16 bits
    set_mode(mode_m & ~16'h0100);
    push(24'hABCDEF);
    cs_lo(); shift(8, 24'h11, junk); shift(16, 0, v);
    shift(8, 24'h12, junk); shift(16, 0, v2); cs_hi(); rdy_m = 1'b0;
    chk("R4 16-bit data", v, 24'h00ABCD);
    chk("R4 command after 16", v2, {8'b0, mode_m});
    set_mode(mode_m | 16'h0100);

    // R8 result during read
    push(24'h111111);
    cs_lo(); shift(8, 24'h11, junk); shift(10, 0, v);
    res_data = 24'h222222; res_vld = 1'b1; wt(1); res_vld = 1'b0;
    shift(14, 0, v2); cs_hi();
    chk("R8 read word held", {v[9:0], v2[13:0]}, 24'h111111);
    chk("R8 rdy after held", {23'b0, rdy}, 24'h1);
    rd(3'd1, 24, v); rdy_m = 1'b0;
    chk("R8 held value applied", v, 24'h222222);

    // R10 aborts
    cs_lo(); shift(8, 24'h02, junk); shift(9, 24'hFFFF, junk); cs_hi();
    rd(3'd2, 16, v); chk("R10 partial write dropped", v, {8'b0, mode_m});
    cs_lo(); shift(3, 24'h7, junk); cs_hi();
    rd(3'd3, 24, v); chk("R10 command restart", v, 24'h000001);

    // R11 continuous read
    cs_lo(); shift(8, 24'h21, junk); cs_hi();
    push(24'h0F0F0F);
    cs_lo(); shift(24, 0, v); cs_hi(); rdy_m = 1'b0;
    chk("R11 stream 1", v, 24'h0F0F0F);
    push(24'hF0F0F0);
    cs_lo(); shift(24, 0, v); cs_hi(); rdy_m = 1'b0;
    chk("R11 stream 2", v, 24'hF0F0F0);
    chk("R11 rdy cleared", {23'b0, rdy}, 24'h0);
    push(24'h765432);
    cs_lo(); shift(24, 24'h300000, v); cs_hi(); rdy_m = 1'b0;
    chk("R11 exit window data", v, 24'h765432);
    rd(3'd2, 16, v); chk("R11 back to commands", v, {8'b0, mode_m});

    // R6 status over all mode field values
    for (int m = 0; m < 8; m++) begin
      set_mode({3'(m), 1'(m), 12'h1B0});
      rd(3'd0, 8, v); chk("R6 status mirror", v, exp_stat());
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule